// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Sequencer

This block sits between an on-chip request port and an external asynchronous byte-wide nonvolatile memory. Each request is a single read or write. A request is taken with a valid/ready handshake and turned into the pin sequence the memory expects: select, write strobe and output-enable levels, a held address, and a data driver that turns on only when it is allowed to. Every phase length is a whole number of clock cycles. The block works these out when it elaborates, from a clock-period parameter and the memory's nanosecond minimums. Each count is the ceiling of the minimum divided by the period, and never less than one cycle.

A write is the stretch during which select and write strobe are both low. The address and data are set up in the same cycle the strobe falls, and they are held for the whole strobe. After the strobe rises, select stays low for a short recovery window with the address still held. A read holds select and output enable low for the access time. The byte on the bus is captured at the last clock edge of that window and returned with a one-cycle valid pulse. Between accesses, select rests high for a guard gap. The gap is stretched when needed, so that two falling edges of select are never closer together than the minimum cycle time.

Top module: `asmc_ctrl`

## Requirements
- R1: While reset is held and just after it is released, select, write strobe and output enable are high (inactive), the data driver is off, ready is high and read-valid is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is low from the next cycle until the access and its guard gap are over (4 busy cycles for either kind at the default 20 ns period). Each acceptance produces exactly one select-low access.
- R3: A write holds select and write strobe low together for the largest of ceil(20/T), ceil(25/T) and ceil(15/T) cycles, which is 2 at 20 ns. Address and write data do not change during that pulse.
- R4: After the write strobe rises, select stays low for ceil(12/T) cycles (1 at 20 ns). The address stays unchanged during that window and throughout any select-low interval.
- R5: The data driver enable is high exactly while the write strobe is low, and it is never high while output enable is low.
- R6: A read holds select and output enable low with the write strobe high for ceil(45/T) cycles (3 at 20 ns). The bus is sampled at the last edge of that window. Read-valid then pulses for one cycle carrying that byte, 3 cycles after the first cycle of the access.
- R7: Between accesses select stays high for at least max(1, ceil(2/T)) cycles, and consecutive falling edges of select are at least ceil(45/T) cycles apart.
- R8: Output enable is low only while select is low and the write strobe is high. The write strobe is low only while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with returned read byte |
| rd_data | output | 8 | Returned read byte |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The bench's memory model drives the inverted byte until the full access time has passed. A controller that captures read data one edge too early therefore returns wrong bytes, and the same model shows that late capture or a bad valid pulse fails the latency check. The strobe width, the recovery length and the busy length are each measured exactly, so a phase count that is off by one shows up as a count mismatch rather than slipping through a lower bound. Back-to-back requests, with the next one raised in the same cycle ready returns, exercise the select fall-to-fall spacing. The same traffic would expose a controller that took one request twice or let the driver overlap output enable. Addresses at both ends of the range and all-zero and all-one bytes catch truncated address or data paths.

// File: rtl/asmc_pkg.sv
package asmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLOW,
        ST_WREC,
        ST_RACC,
        ST_GAP
    } asmc_state_e;

    // ceiling of ns / period, never less than one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asmc_phase_timer.sv
module asmc_phase_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asmc_rd_capture.sv
module asmc_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = cap_en;
        if (cap_en) begin
            c_d.dat = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_valid = c_q.vld;
    assign rd_data  = c_q.dat;

    // R6: the returned valid is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asmc_ctrl.sv
module asmc_ctrl
    import asmc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_NS   = 20,
    parameter int unsigned T_CYC_NS = 45,
    parameter int unsigned T_ACC_NS = 45,
    parameter int unsigned T_WP_NS  = 20,
    parameter int unsigned T_AW_NS  = 25,
    parameter int unsigned T_DS_NS  = 15,
    parameter int unsigned T_WR_NS  = 12,
    parameter int unsigned T_HI_NS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // phase lengths in cycles
    localparam int unsigned N_CYC  = ns2cyc(T_CYC_NS, CLK_NS);
    localparam int unsigned N_ACC  = ns2cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned N_WLOW = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                          ns2cyc(T_DS_NS, CLK_NS));
    localparam int unsigned N_WREC = ns2cyc(T_WR_NS, CLK_NS);
    localparam int unsigned N_HI   = ns2cyc(T_HI_NS, CLK_NS);
    localparam int unsigned N_GAPW = (N_CYC > N_WLOW + N_WREC + N_HI) ? (N_CYC - N_WLOW - N_WREC) : N_HI;
    localparam int unsigned N_GAPR = (N_CYC > N_ACC + N_HI) ? (N_CYC - N_ACC) : N_HI;
    localparam int unsigned N_MAX  = umax(umax(umax(N_CYC, N_ACC), umax(N_WLOW, N_WREC)),
                                          umax(N_GAPW, N_GAPR));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    typedef struct packed {
        asmc_state_e       st;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                 dq_oe: 1'b0, addr: '0, wdata: '0};

    ctl_t          r_d, r_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cap_en;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.ce_n = 1'b0;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        r_d.wdata = req_wdata;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.st    = ST_WLOW;
                        tmr_val   = CW'(N_WLOW - 1);
                    end else begin
                        r_d.oe_n  = 1'b0;
                        r_d.st    = ST_RACC;
                        tmr_val   = CW'(N_ACC - 1);
                    end
                end
            end
            ST_WLOW: begin
                if (tmr_expired) begin
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.st    = ST_WREC;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(N_WREC - 1);
                end
            end
            ST_WREC: begin
                if (tmr_expired) begin
                    r_d.ce_n = 1'b1;
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_GAPW - 1);
                end
            end
            ST_RACC: begin
                if (tmr_expired) begin
                    cap_en   = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_GAPR - 1);
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    asmc_phase_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asmc_rd_capture #(.DW(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .din      (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

    // checker counters: consecutive strobe-low cycles, cycles since select fell
    logic [CW-1:0] we_lo_q;
    logic [CW-1:0] ce_age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_q  <= '0;
            ce_age_q <= CW'(N_CYC);
        end else begin
            if (!mem_we_n) begin
                we_lo_q <= (we_lo_q == CW'(N_MAX)) ? we_lo_q : we_lo_q + 1'b1;
            end else begin
                we_lo_q <= '0;
            end
            if ($fell(mem_ce_n)) begin
                ce_age_q <= CW'(1);
            end else if (ce_age_q < CW'(N_CYC)) begin
                ce_age_q <= ce_age_q + 1'b1;
            end
        end
    end

    a_r1_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r5_driver_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

    a_r8_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r8_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q >= CW'(N_WLOW)));

    a_r7_fall_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_age_q >= CW'(N_CYC)));

    a_r2_no_select_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> mem_ce_n);

endmodule

// File: tb/sim_asmc_ctrl.sv
module sim_asmc_ctrl;

    localparam int PER = 20;
    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_CYC  = cdiv(45);
    localparam int E_ACC  = cdiv(45);
    localparam int E_WLOW = imax(imax(cdiv(20), cdiv(25)), cdiv(15));
    localparam int E_WREC = cdiv(12);
    localparam int E_HI   = cdiv(2);
    localparam int E_GAPW = imax(E_HI, E_CYC - E_WLOW - E_WREC);
    localparam int E_GAPR = imax(E_HI, E_CYC - E_ACC);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    always #(PER/2) clk = ~clk;

    asmc_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int accepts = 0;
    int falls   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench expectation and pin-side memory model
    logic [7:0] ref_mem [int];
    logic [7:0] mdl [int];

    function automatic logic [7:0] ref_peek(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] mdl_peek(input int a);
        return mdl.exists(a) ? mdl[a] : 8'h00;
    endfunction

    typedef struct { logic [7:0] d; int c; } exp_t;
    exp_t sbq[$];

    // pin monitor, memory model and scoreboard, all at the falling edge
    int          we_run = 0, wrec_run = 0, rd_age = 0, since_fall = 0, hi_run = 0;
    bit          after_wr = 0, prev_ce_lo = 0, prev_we_lo = 0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n || mem_dq_oe) begin
                chk(mem_dq_oe == !mem_we_n, "R5", "driver tracks strobe", mem_dq_oe, !mem_we_n);
                chk(!(mem_dq_oe && !mem_oe_n), "R5", "driver with oe low", 1, 0);
                chk(mem_oe_n || (!mem_ce_n && mem_we_n), "R8", "oe qualification", mem_oe_n, 1);
                chk(mem_we_n || !mem_ce_n, "R8", "strobe qualification", mem_we_n, 1);
            end
            if (!mem_ce_n && prev_ce_lo)
                chk(mem_addr == prev_addr, "R4", "address held while selected", mem_addr, prev_addr);
            if (!mem_ce_n && !prev_ce_lo) begin
                if (falls > 0) begin
                    chk(since_fall >= E_CYC, "R7", "select fall spacing", since_fall, E_CYC);
                    chk(hi_run >= E_HI, "R7", "select high gap", hi_run, E_HI);
                end
                falls++;
                since_fall = 0;
            end
            if (!mem_we_n) begin
                if (prev_we_lo)
                    chk(mem_dq_out == prev_dq, "R3", "data held in strobe", mem_dq_out, prev_dq);
                we_run++;
            end else if (prev_we_lo) begin
                chk(we_run == E_WLOW, "R3", "strobe width", we_run, E_WLOW);
                we_run = 0;
                after_wr = 1;
                wrec_run = 0;
            end
            if (after_wr && !mem_ce_n && mem_we_n) wrec_run++;
            if (mem_ce_n && prev_ce_lo && after_wr) begin
                chk(wrec_run == E_WREC, "R4", "recovery length", wrec_run, E_WREC);
                after_wr = 0;
            end
            if (!mem_ce_n && !mem_we_n) mdl[int'(mem_addr)] = mem_dq_out;
            if (rd_valid) begin
                if (sbq.size() == 0) begin
                    chk(0, "R6", "unexpected read valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rd_data == e.d, "R6", "read byte", rd_data, e.d);
                    chk(cyc - e.c == E_ACC, "R6", "read latency", cyc - e.c, E_ACC);
                end
            end
        end
        since_fall++;
        hi_run = mem_ce_n ? hi_run + 1 : 0;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++;
        else rd_age = 0;
        // bus shows the wrong byte until the access time has elapsed
        mem_dq_in = (rd_age >= E_ACC) ? mdl_peek(int'(mem_addr)) : ~mdl_peek(int'(mem_addr));
        prev_ce_lo = !mem_ce_n;
        prev_we_lo = !mem_we_n;
        prev_addr  = mem_addr;
        prev_dq    = mem_dq_out;
    end

    // driver: called at a falling edge
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int busy;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        accepts++;
        if (wr) ref_mem[int'(a)] = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) sbq.push_back('{d: ref_peek(int'(a)), c: cyc});
        chk(!req_ready, "R2", "ready drops after accept", req_ready, 0);
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        if (wr) chk(busy == E_WLOW + E_WREC + E_GAPW, "R2", "write busy cycles", busy, E_WLOW + E_WREC + E_GAPW);
        else    chk(busy == E_ACC + E_GAPR, "R2", "read busy cycles", busy, E_ACC + E_GAPR);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(PER * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "controls high in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dq_oe && !rd_valid, "R1", "driver off and no valid in reset", {mem_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "quiet after reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        // R3 R6: address and data extremes
        issue(1, 15'h0000, 8'hA5);
        issue(1, 15'h7FFF, 8'h5A);
        issue(1, 15'h1234, 8'hFF);
        issue(1, 15'h4321, 8'h00);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(0, 15'h4321, 8'h00);
        issue(0, 15'h0F0F, 8'h00);   // never written
        issue(1, 15'h1234, 8'h3C);   // overwrite
        issue(0, 15'h1234, 8'h00);

        // R7: back-to-back traffic with walking addresses
        for (int i = 0; i < 16; i++) issue(1, 15'(i * 16'h0801), 8'(i * 17) ^ 8'h96);
        for (int i = 15; i >= 0; i--) issue(0, 15'(i * 16'h0801), 8'h00);
        for (int i = 0; i < 8; i++) begin
            issue(1, 15'h2AAA, 8'(8'h01 << i));
            issue(0, 15'h2AAA, 8'h00);
        end

        // R2: idle with no request leaves the pins quiet
        repeat (10) begin
            @(negedge clk);
            chk(mem_ce_n && mem_we_n && mem_oe_n, "R2", "idle pins", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        end
        chk(sbq.size() == 0, "R6", "all reads returned", sbq.size(), 0);
        chk(falls == accepts, "R2", "one access per acceptance", falls, accepts);
        finish_run();
    end

endmodule